// File: doc/BRIEF.md
# Weak-Ordering Memory Issue Controller

This block sits between one in-order processor request port and a memory side that accepts several requests at once. Every request is marked as either a plain data access or a synchronization access. Data reads go straight to memory and may return in any order. Data writes go into a small pending-write buffer. From there they are sent to memory on their own, and each write stays pending until the memory side has returned the number of invalidation acknowledgements that the processor attached to it. A read whose address hits a pending write never goes to memory. It is answered from the youngest matching buffer entry.

A counter of outstanding operations holds back every synchronization request until all older reads have returned and all older writes have collected their acknowledgements. While a synchronization access is in flight, no younger request is accepted. Nothing can move across it in either direction, so the processor gets a clean fence with no separate fence instruction. `req_ready` is combinational in the request fields, because a read's readiness depends on whether it forwards from the buffer, on the read slots and on the memory port.

Top module: `wo_issue_ctrl`

## Requirements
- R1: After reset no operation is outstanding. `mem_req_valid` and `cpu_rsp_valid` are low, and an ordinary read is ready to be accepted.
- R2: A request with `req_sync` high is accepted only when no earlier read is awaiting data and no earlier write is awaiting acknowledgements.
- R3: From the acceptance of a synchronization request until it completes, `req_ready` stays low for every request. It rises again one cycle after the completion.
- R4: A write is complete only once the number of `mem_ack_valid` pulses carrying its tag equals its `req_acks` value. A write whose value is zero completes one cycle after memory accepts it.
- R5: A read to an address that matches no pending write is sent to memory while older writes to other addresses are still pending.
- R6: A read whose address matches a pending write sends nothing to memory. One cycle after acceptance it returns that write's data, with `cpu_rsp_fwd` high and its own `req_id`.
- R7: When several pending writes match a read address, the data comes from the youngest of them.
- R8: Writes to the same address reach memory in program order. A younger one is not sent until the older one has completed.
- R9: The write buffer holds 4 entries. While it is full, `req_ready` is low for writes.
- R10: At most 4 reads can await data. With 4 outstanding, `req_ready` is low for a fifth read that does not forward.
- R11: A memory read response is returned on the processor side one cycle later, with `cpu_rsp_fwd` low and the `req_id` of the read it answers. Responses may come back in any order.
- R12: The top bit of `mem_req_tag` is 1 for a read and 0 for a write. The low bits are the slot index that the memory side echoes on `mem_rsp_tag` or `mem_ack_tag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sync | input | 1 | 1 = synchronization class, 0 = data class |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| req_acks | input | CW | Acknowledgements expected for this write |
| req_id | input | IDW | Processor tag returned with read data |
| cpu_rsp_valid | output | 1 | Read response present |
| cpu_rsp_fwd | output | 1 | Response was served from the write buffer |
| cpu_rsp_id | output | IDW | Tag of the read being answered |
| cpu_rsp_data | output | DW | Read data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | Memory request is a write |
| mem_req_sync | output | 1 | Memory request is a synchronization access |
| mem_req_addr | output | AW | Memory request address |
| mem_req_wdata | output | DW | Memory write data |
| mem_req_tag | output | IXW+1 | Kind bit and slot index |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_tag | input | IXW | Read slot being answered |
| mem_rsp_data | input | DW | Returned read data |
| mem_ack_valid | input | 1 | One invalidation acknowledgement |
| mem_ack_tag | input | IXW | Write slot acknowledged |

## Verification
The hardest state to reach is a full buffer holding several writes to one address. In that state only the oldest may be in memory, and a read must pick the youngest copy. The bench sweeps the depth of such a chain from one to four entries and stops memory acknowledgements to hold every write pending. It then reads the shared address and releases the writes one acknowledgement at a time, observing the issue order on the memory port. The fence is reached in a similar way. Partial acknowledgements leave a write incomplete, and the bench probes the port in each state before the last acknowledgement lands.

// File: rtl/wo_issue_pkg.sv
package wo_issue_pkg;

  typedef enum logic {
    CLS_DATA = 1'b0,
    CLS_SYNC = 1'b1
  } req_class_e;

  typedef enum logic {
    TAG_WRITE = 1'b0,
    TAG_READ  = 1'b1
  } tag_kind_e;

endpackage

// File: rtl/wo_write_buf.sv
module wo_write_buf #(
  parameter int N   = 4,
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int CW  = 3,
  parameter int IXW = 2,
  parameter int DCW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           alloc_en,
  input  logic [AW-1:0]  alloc_addr,
  input  logic [DW-1:0]  alloc_data,
  input  logic [CW-1:0]  alloc_need,
  input  logic           alloc_sync,
  output logic           full,
  input  logic [AW-1:0]  lkp_addr,
  output logic           hit,
  output logic [DW-1:0]  hit_data,
  output logic           iss_valid,
  output logic [IXW-1:0] iss_idx,
  output logic [AW-1:0]  iss_addr,
  output logic [DW-1:0]  iss_data,
  output logic           iss_sync,
  input  logic           iss_take,
  input  logic           ack_valid,
  input  logic [IXW-1:0] ack_idx,
  output logic [DCW-1:0] done_cnt
);

  logic [N-1:0]  vld, iss, syn;
  logic [AW-1:0] addr_q [N];
  logic [DW-1:0] data_q [N];
  logic [CW-1:0] need_q [N];
  logic [CW-1:0] got_q  [N];
  logic [N-1:0]  older  [N];   // older[i][j] set: entry i was written before entry j

  logic [N-1:0]   done_v, match_v, young_v, blk_v, elig_v, pick_v;
  logic [IXW-1:0] free_idx;

  function automatic logic ack_done(input logic [CW-1:0] got, input logic [CW-1:0] need);
    return got == need;
  endfunction

  always_comb begin
    free_idx  = '0;
    done_cnt  = '0;
    hit_data  = '0;
    iss_idx   = '0;
    iss_addr  = '0;
    iss_data  = '0;
    iss_sync  = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld[i]) free_idx = IXW'(i);
    end
    for (int i = 0; i < N; i++) begin
      done_v[i]  = vld[i] && iss[i] && ack_done(got_q[i], need_q[i]);
      match_v[i] = vld[i] && (addr_q[i] == lkp_addr);
      blk_v[i]   = 1'b0;
      for (int j = 0; j < N; j++) begin
        if (vld[j] && older[j][i] && (addr_q[j] == addr_q[i])) blk_v[i] = 1'b1;
      end
    end
    for (int i = 0; i < N; i++) begin
      young_v[i] = match_v[i] && ((match_v & older[i]) == '0);
      elig_v[i]  = vld[i] && !iss[i] && !blk_v[i];
    end
    for (int i = 0; i < N; i++) begin
      pick_v[i] = elig_v[i];
      for (int j = 0; j < N; j++) begin
        if (elig_v[j] && older[j][i]) pick_v[i] = 1'b0;
      end
    end
    for (int i = 0; i < N; i++) begin
      done_cnt = done_cnt + DCW'(done_v[i]);
      if (young_v[i]) hit_data = data_q[i];
      if (pick_v[i]) begin
        iss_idx  = IXW'(i);
        iss_addr = addr_q[i];
        iss_data = data_q[i];
        iss_sync = syn[i];
      end
    end
  end

  assign full      = &vld;
  assign hit       = |match_v;
  assign iss_valid = |pick_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      iss <= '0;
      syn <= '0;
      for (int i = 0; i < N; i++) begin
        addr_q[i] <= '0;
        data_q[i] <= '0;
        need_q[i] <= '0;
        got_q[i]  <= '0;
        older[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (alloc_en && (free_idx == IXW'(i))) begin
          vld[i]    <= 1'b1;
          iss[i]    <= 1'b0;
          syn[i]    <= alloc_sync;
          addr_q[i] <= alloc_addr;
          data_q[i] <= alloc_data;
          need_q[i] <= alloc_need;
          got_q[i]  <= '0;
          older[i]  <= '0;
        end else if (done_v[i]) begin
          vld[i] <= 1'b0;
          iss[i] <= 1'b0;
        end else begin
          if (iss_take && (iss_idx == IXW'(i))) iss[i] <= 1'b1;
          if (ack_valid && (ack_idx == IXW'(i)) && vld[i] && !ack_done(got_q[i], need_q[i]))
            got_q[i] <= got_q[i] + CW'(1);
        end
        if (alloc_en && (free_idx != IXW'(i))) older[i][free_idx] <= vld[i];
      end
    end
  end

  for (genvar gi = 0; gi < N; gi++) begin : g_chk
    assert_free_after_acks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vld[gi]) |-> $past(iss[gi] && (got_q[gi] == need_q[gi])));
    for (genvar gj = 0; gj < N; gj++) begin : g_pair
      if (gi != gj) begin : g_ne
        assert_same_addr_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
          (vld[gi] && vld[gj] && older[gj][gi] && (addr_q[gi] == addr_q[gj]))
            |-> !(iss[gi] && !iss[gj]));
      end
    end
  end

endmodule

// File: rtl/wo_read_slots.sv
module wo_read_slots #(
  parameter int NRD = 4,
  parameter int IDW = 4,
  parameter int IXW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           alloc_en,
  input  logic [IDW-1:0] alloc_id,
  output logic           full,
  output logic [IXW-1:0] free_idx,
  input  logic           rsp_valid,
  input  logic [IXW-1:0] rsp_idx,
  output logic [IDW-1:0] rsp_id
);

  logic [NRD-1:0] vld;
  logic [IDW-1:0] id_q [NRD];

  always_comb begin
    free_idx = '0;
    for (int i = NRD - 1; i >= 0; i--) begin
      if (!vld[i]) free_idx = IXW'(i);
    end
  end

  assign full   = &vld;
  assign rsp_id = id_q[rsp_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < NRD; i++) id_q[i] <= '0;
    end else begin
      for (int i = 0; i < NRD; i++) begin
        if (alloc_en && (free_idx == IXW'(i))) begin
          vld[i]  <= 1'b1;
          id_q[i] <= alloc_id;
        end else if (rsp_valid && (rsp_idx == IXW'(i))) begin
          vld[i] <= 1'b0;
        end
      end
    end
  end

  assert_rsp_live_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> vld[rsp_idx]);

  assert_alloc_room_R10: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !full);

endmodule

// File: rtl/wo_outstanding_gate.sv
module wo_outstanding_gate #(
  parameter int OCNT = 8,
  parameter int OCW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           inc,
  input  logic [OCW-1:0] dec_w,
  input  logic           dec_r,
  input  logic           sync_acc,
  output logic [OCW-1:0] cnt,
  output logic           idle,
  output logic           at_limit,
  output logic           sync_busy
);

  function automatic logic [OCW-1:0] cnt_next(input logic [OCW-1:0] c, input logic up,
                                              input logic [OCW-1:0] dw, input logic dr);
    return c + OCW'(up) - dw - OCW'(dr);
  endfunction

  logic [OCW:0] take_sum, have_sum;

  assign idle     = (cnt == '0);
  assign at_limit = (cnt == OCW'(OCNT));
  assign take_sum = {1'b0, dec_w} + (OCW+1)'(dec_r);
  assign have_sum = {1'b0, cnt} + (OCW+1)'(inc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      sync_busy <= 1'b0;
    end else begin
      cnt <= cnt_next(cnt, inc, dec_w, dec_r);
      if (sync_acc)  sync_busy <= 1'b1;
      else if (idle) sync_busy <= 1'b0;
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= OCW'(OCNT));

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_sum <= have_sum);

  assert_sync_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_acc |-> idle);

endmodule

// File: rtl/wo_issue_ctrl.sv
module wo_issue_ctrl #(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int CW  = 3,
  parameter int IDW = 4,
  parameter int NWB = 4,
  parameter int NRD = 4,
  localparam int IXW  = $clog2((NWB > NRD) ? NWB : NRD),
  localparam int TW   = IXW + 1,
  localparam int OCNT = NWB + NRD,
  localparam int OCW  = $clog2(OCNT + 1),
  localparam int DCW  = $clog2(NWB + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic           req_sync,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  logic [CW-1:0]  req_acks,
  input  logic [IDW-1:0] req_id,
  output logic           cpu_rsp_valid,
  output logic           cpu_rsp_fwd,
  output logic [IDW-1:0] cpu_rsp_id,
  output logic [DW-1:0]  cpu_rsp_data,
  output logic           mem_req_valid,
  input  logic           mem_req_ready,
  output logic           mem_req_write,
  output logic           mem_req_sync,
  output logic [AW-1:0]  mem_req_addr,
  output logic [DW-1:0]  mem_req_wdata,
  output logic [TW-1:0]  mem_req_tag,
  input  logic           mem_rsp_valid,
  input  logic [IXW-1:0] mem_rsp_tag,
  input  logic [DW-1:0]  mem_rsp_data,
  input  logic           mem_ack_valid,
  input  logic [IXW-1:0] mem_ack_tag
);

  import wo_issue_pkg::*;

  logic           wb_full, wb_hit, wb_iss_valid, wb_iss_sync, wb_iss_take;
  logic [DW-1:0]  wb_hit_data, wb_iss_data;
  logic [AW-1:0]  wb_iss_addr;
  logic [IXW-1:0] wb_iss_idx;
  logic [DCW-1:0] wb_done_cnt;
  logic           rd_full;
  logic [IXW-1:0] rd_free_idx;
  logic [IDW-1:0] rd_rsp_id;
  logic [OCW-1:0] out_cnt;
  logic           gate_idle, gate_limit, sync_busy;

  // named events used by the assertions and the counter
  logic is_read, fwd_hit, rd_mem_ok, wr_ok, blocked;
  logic rd_want, acc, acc_wr, acc_rd_mem, acc_fwd, acc_sync;
  req_class_e req_cls;

  assign req_cls   = req_sync ? CLS_SYNC : CLS_DATA;
  assign is_read   = !req_write;
  assign fwd_hit   = is_read && wb_hit;
  assign rd_mem_ok = is_read && !wb_hit && !rd_full;
  assign wr_ok     = req_write && !wb_full;
  assign blocked   = sync_busy || gate_limit || ((req_cls == CLS_SYNC) && !gate_idle);

  assign rd_want   = req_valid && !blocked && rd_mem_ok;
  assign req_ready = !blocked && (wr_ok || (fwd_hit && !mem_rsp_valid) ||
                                  (rd_mem_ok && mem_req_ready));

  assign acc        = req_valid && req_ready;
  assign acc_wr     = acc && req_write;
  assign acc_rd_mem = acc && is_read && !wb_hit;
  assign acc_fwd    = acc && fwd_hit;
  assign acc_sync   = acc && (req_cls == CLS_SYNC);

  // reads from the processor take the port; buffered writes fill the gaps
  assign wb_iss_take   = !rd_want && wb_iss_valid && mem_req_ready;
  assign mem_req_valid = rd_want || wb_iss_valid;
  assign mem_req_write = !rd_want;
  assign mem_req_sync  = rd_want ? req_sync : wb_iss_sync;
  assign mem_req_addr  = rd_want ? req_addr : wb_iss_addr;
  assign mem_req_wdata = rd_want ? '0 : wb_iss_data;
  assign mem_req_tag   = rd_want ? {TAG_READ, rd_free_idx} : {TAG_WRITE, wb_iss_idx};

  wo_write_buf #(
    .N(NWB), .AW(AW), .DW(DW), .CW(CW), .IXW(IXW), .DCW(DCW)
  ) wbuf_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_en   (acc_wr),
    .alloc_addr (req_addr),
    .alloc_data (req_wdata),
    .alloc_need (req_acks),
    .alloc_sync (req_sync),
    .full       (wb_full),
    .lkp_addr   (req_addr),
    .hit        (wb_hit),
    .hit_data   (wb_hit_data),
    .iss_valid  (wb_iss_valid),
    .iss_idx    (wb_iss_idx),
    .iss_addr   (wb_iss_addr),
    .iss_data   (wb_iss_data),
    .iss_sync   (wb_iss_sync),
    .iss_take   (wb_iss_take),
    .ack_valid  (mem_ack_valid),
    .ack_idx    (mem_ack_tag),
    .done_cnt   (wb_done_cnt)
  );

  wo_read_slots #(
    .NRD(NRD), .IDW(IDW), .IXW(IXW)
  ) rslot_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (acc_rd_mem),
    .alloc_id  (req_id),
    .full      (rd_full),
    .free_idx  (rd_free_idx),
    .rsp_valid (mem_rsp_valid),
    .rsp_idx   (mem_rsp_tag),
    .rsp_id    (rd_rsp_id)
  );

  wo_outstanding_gate #(
    .OCNT(OCNT), .OCW(OCW)
  ) gate_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc       (acc_wr || acc_rd_mem),
    .dec_w     (OCW'(wb_done_cnt)),
    .dec_r     (mem_rsp_valid),
    .sync_acc  (acc_sync),
    .cnt       (out_cnt),
    .idle      (gate_idle),
    .at_limit  (gate_limit),
    .sync_busy (sync_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_fwd   <= 1'b0;
      cpu_rsp_id    <= '0;
      cpu_rsp_data  <= '0;
    end else if (mem_rsp_valid) begin
      cpu_rsp_valid <= 1'b1;
      cpu_rsp_fwd   <= 1'b0;
      cpu_rsp_id    <= rd_rsp_id;
      cpu_rsp_data  <= mem_rsp_data;
    end else if (acc_fwd) begin
      cpu_rsp_valid <= 1'b1;
      cpu_rsp_fwd   <= 1'b1;
      cpu_rsp_id    <= req_id;
      cpu_rsp_data  <= wb_hit_data;
    end else begin
      cpu_rsp_valid <= 1'b0;
    end
  end

  assert_fwd_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fwd |=> (cpu_rsp_valid && cpu_rsp_fwd));

  assert_fwd_no_mem_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fwd |-> !(mem_req_valid && !mem_req_write));

  assert_mem_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |=> (cpu_rsp_valid && !cpu_rsp_fwd));

  assert_sync_alone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sync_busy |-> !acc);

  assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> (out_cnt < OCW'(OCNT)));

endmodule

// File: tb/wo_issue_ctrl_tb_top.sv
module wo_issue_ctrl_tb_top;
  localparam int AW = 16, DW = 16, CW = 3, IDW = 4, NWB = 4, NRD = 4;
  localparam int IXW = 2, TW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_sync = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [CW-1:0] req_acks = '0;
  logic [IDW-1:0] req_id = '0;
  logic req_ready;
  logic cpu_rsp_valid, cpu_rsp_fwd;
  logic [IDW-1:0] cpu_rsp_id;
  logic [DW-1:0] cpu_rsp_data;
  logic mem_req_valid, mem_req_write, mem_req_sync;
  logic mem_req_ready = 1'b1;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic [TW-1:0] mem_req_tag;
  logic mem_rsp_valid = 0;
  logic [IXW-1:0] mem_rsp_tag = '0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic mem_ack_valid = 0;
  logic [IXW-1:0] mem_ack_tag = '0;

  always #5 clk = ~clk;

  wo_issue_ctrl #(.AW(AW), .DW(DW), .CW(CW), .IDW(IDW), .NWB(NWB), .NRD(NRD)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_sync(req_sync),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_acks(req_acks), .req_id(req_id),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_fwd(cpu_rsp_fwd), .cpu_rsp_id(cpu_rsp_id),
    .cpu_rsp_data(cpu_rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_sync(mem_req_sync), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_req_tag(mem_req_tag),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag), .mem_rsp_data(mem_rsp_data),
    .mem_ack_valid(mem_ack_valid), .mem_ack_tag(mem_ack_tag)
  );

  int n_cmp = 0, n_bad = 0;
  bit done_flag = 0;

  // log of every request the memory side accepts
  logic          lg_wr   [256];
  logic          lg_sy   [256];
  logic [AW-1:0] lg_addr [256];
  logic [DW-1:0] lg_data [256];
  logic [TW-1:0] lg_tag  [256];
  int lg_n = 0;

  always @(posedge clk) begin
    if (rst_n && mem_req_valid && mem_req_ready && lg_n < 256) begin
      lg_wr[lg_n]   <= mem_req_write;
      lg_sy[lg_n]   <= mem_req_sync;
      lg_addr[lg_n] <= mem_req_addr;
      lg_data[lg_n] <= mem_req_wdata;
      lg_tag[lg_n]  <= mem_req_tag;
      lg_n <= lg_n + 1;
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic s, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic [CW-1:0] n, input logic [IDW-1:0] id);
    req_write = w; req_sync = s; req_addr = a; req_wdata = d; req_acks = n; req_id = id;
    req_valid = 1'b1;
  endtask

  task automatic drop_req();
    req_valid = 1'b0; req_write = 1'b0; req_sync = 1'b0;
    req_addr = '0; req_wdata = '0; req_acks = '0; req_id = '0;
  endtask

  task automatic send(input logic w, input logic s, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic [CW-1:0] n, input logic [IDW-1:0] id);
    @(negedge clk);
    drive(w, s, a, d, n, id);
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    drop_req();
  endtask

  task automatic probe(input logic w, input logic s, input logic [AW-1:0] a,
                       input logic [IDW-1:0] id, output logic rdy);
    @(negedge clk);
    drive(w, s, a, '0, '0, id);
    #1;
    rdy = req_ready;
    #1;
    drop_req();
  endtask

  task automatic ack(input logic [IXW-1:0] t);
    @(negedge clk);
    mem_ack_valid = 1'b1; mem_ack_tag = t;
    @(negedge clk);
    mem_ack_valid = 1'b0;
  endtask

  task automatic rrsp(input logic [IXW-1:0] t, input logic [DW-1:0] d);
    @(negedge clk);
    mem_rsp_valid = 1'b1; mem_rsp_tag = t; mem_rsp_data = d;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic rdy;
    int wi, ri, base, cnt_b;
    int rtag [4];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 ready after reset", req_ready, 1);
    chk("R1 no mem request", mem_req_valid, 0);
    chk("R1 no cpu response", cpu_rsp_valid, 0);

    // pending write, then a bypassing read to another address
    send(1, 0, 16'h0010, 16'hAAAA, 3'd2, 4'd1);
    repeat (2) @(negedge clk);
    wi = lg_n - 1;
    chk("R12 write tag kind", lg_tag[wi][IXW], 0);
    chk("R12 write addr", lg_addr[wi], 16'h0010);
    send(0, 0, 16'h0020, '0, '0, 4'd3);
    ri = lg_n - 1;
    chk("R5 read issued past pending write", lg_addr[ri], 16'h0020);
    chk("R12 read tag kind", lg_tag[ri][IXW], 1);
    rrsp(lg_tag[ri][IXW-1:0], 16'h1234);
    chk("R11 rsp valid", cpu_rsp_valid, 1);
    chk("R11 rsp id", cpu_rsp_id, 3);
    chk("R11 rsp data", cpu_rsp_data, 16'h1234);
    chk("R11 rsp not forwarded", cpu_rsp_fwd, 0);

    // read of own pending write
    cnt_b = lg_n;
    send(0, 0, 16'h0010, '0, '0, 4'd5);
    chk("R6 fwd valid", cpu_rsp_valid, 1);
    chk("R6 fwd flag", cpu_rsp_fwd, 1);
    chk("R6 fwd data", cpu_rsp_data, 16'hAAAA);
    chk("R6 fwd id", cpu_rsp_id, 5);
    @(negedge clk);
    chk("R6 no memory read", lg_n, cnt_b);

    // fence behind a write that needs two acknowledgements
    probe(0, 1, 16'h0030, 4'd6, rdy);
    chk("R2 sync held, write pending", rdy, 0);
    ack(lg_tag[wi][IXW-1:0]);
    probe(0, 1, 16'h0030, 4'd6, rdy);
    chk("R4 one of two acks not complete", rdy, 0);
    ack(lg_tag[wi][IXW-1:0]);
    probe(0, 1, 16'h0030, 4'd6, rdy);
    chk("R4 complete after all acks", rdy, 1);
    send(0, 1, 16'h0030, '0, '0, 4'd6);
    ri = lg_n - 1;
    chk("R2 sync reaches memory", lg_sy[ri], 1);
    probe(0, 0, 16'h0031, 4'd7, rdy);
    chk("R3 read blocked behind sync", rdy, 0);
    probe(1, 0, 16'h0032, 4'd7, rdy);
    chk("R3 write blocked behind sync", rdy, 0);
    rrsp(lg_tag[ri][IXW-1:0], 16'h5555);
    chk("R11 sync read id", cpu_rsp_id, 6);
    probe(0, 0, 16'h0031, 4'd7, rdy);
    chk("R3 released after sync", rdy, 1);

    // chains of same-address writes, depth 1..4
    for (int k = 1; k <= 4; k++) begin
      base = lg_n;
      for (int j = 0; j < k; j++)
        send(1, 0, 16'h0040 + 16'(k), 16'h0100 + 16'(16 * k + j), 3'd1, 4'd0);
      repeat (2) @(negedge clk);
      send(0, 0, 16'h0040 + 16'(k), '0, '0, 4'd7);
      chk("R7 youngest forwarded", cpu_rsp_data, 16'h0100 + 16'(16 * k + k - 1));
      chk("R6 forwarded flag", cpu_rsp_fwd, 1);
      chk("R8 only oldest issued", lg_n - base, 1);
      if (k == 4) begin
        probe(1, 0, 16'h0070, 4'd0, rdy);
        chk("R9 write stalls on full buffer", rdy, 0);
      end
      for (int j = 0; j < k; j++) begin
        wi = lg_n - 1;
        chk("R8 issue order", lg_data[wi], 16'h0100 + 16'(16 * k + j));
        ack(lg_tag[wi][IXW-1:0]);
        repeat (4) @(negedge clk);
      end
      chk("R8 all issued", lg_n - base, k);
    end

    // four reads in flight, answered in reverse order
    for (int i = 0; i < 4; i++) begin
      send(0, 0, 16'h0050 + 16'(i), '0, '0, 4'(8 + i));
      rtag[i] = int'(lg_tag[lg_n - 1][IXW-1:0]);
    end
    probe(0, 0, 16'h0058, 4'd12, rdy);
    chk("R10 fifth read stalls", rdy, 0);
    for (int i = 3; i >= 0; i--) begin
      rrsp(IXW'(rtag[i]), 16'h0700 + 16'(i));
      chk("R11 out-of-order id", cpu_rsp_id, 8 + i);
      chk("R11 out-of-order data", cpu_rsp_data, 16'h0700 + 16'(i));
    end

    // write with no acknowledgements expected
    send(1, 0, 16'h0060, 16'h0BEE, 3'd0, 4'd0);
    repeat (3) @(negedge clk);
    probe(0, 1, 16'h0061, 4'd1, rdy);
    chk("R4 zero-ack write completes", rdy, 1);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule